// File: doc/BRIEF.md
# Device-to-Host Transfer Sequencer

This block moves one block of local memory to the host in two steps. After a start pulse it asks the host for a destination buffer and waits for the reply. The reply is a ready pulse that carries a bus address and a buffer size written as a power-of-two exponent. When a good reply arrives, the block issues one DMA request. The request carries the local source address, the host address, a byte count and a flag that tells the host to raise its own completion interrupt. The block then waits for the DMA engine to report completion.

The host may take any amount of time to answer the buffer request, so the block runs its own timer, which is programmable per transfer. Three events send the sequencer to an error interrupt: the timer runs out, the host flags a bad buffer, or the DMA engine reports a failed transfer. The interrupt stays raised, with its error qualifier, until it is acknowledged. The DMA engine and the bus fabric sit outside the block and are seen only through their request, acknowledge and completion pulses.

Top module: `d2h_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `bufReq`, `dmaReq`, `irq`, `irqErr`, `xferDone` and `xferErr` are all low.
- R2: A `start` pulse while idle captures `srcAddr`, `reqLen` and `notifyHost`, and `bufReq` is high from the next cycle on. `bufReq` stays high until a cycle in which `bufReqAck` or `bufRdy` is high.
- R3: A `bufRdy` pulse with `bufErr` low is accepted in the request phase or in the reply-wait phase. In the next cycle `dmaReq` is high and `dmaDst` equals the `bufAddr` seen with that pulse.
- R4: `dmaLen` equals the smaller of the captured length and 2^`bufSize` bytes; for example, `bufSize` = 10 means 1024 bytes. A `bufSize` at or above the length width leaves the length unclipped.
- R5: While `dmaReq` is high, `dmaSrc`, `dmaDst`, `dmaLen` and `dmaSig` hold their values. `dmaSrc` is the captured source, and `dmaSig` is the captured `notifyHost`. `dmaReq` stays high until `dmaAck` pulses.
- R6: After the DMA acknowledge, a `dmaDone` pulse with `dmaErr` low gives a one-cycle `xferDone` in that same cycle, and the block is idle from the next cycle.
- R7: Count the first cycle of `bufReq` as cycle 0. If no `bufRdy` arrives in cycles 0 to `timeoutCycles`-1, `irq` and `irqErr` rise in cycle `timeoutCycles`. A `bufRdy` in cycle `timeoutCycles`-1 is still accepted. A value of 0 acts as 1.
- R8: A `bufRdy` pulse with `bufErr` high raises `irq` with `irqErr` in the next cycle, and no DMA request is issued.
- R9: A `dmaDone` pulse with `dmaErr` high raises `irq` with `irqErr` in the next cycle, and `xferDone` stays low.
- R10: `irq` and `irqErr` stay high until `irqAck`. In the acknowledge cycle `xferErr` is high for one cycle, and the block is idle from the next cycle.
- R11: The block ignores `start` while busy. It ignores `bufRdy` outside the request and reply-wait phases, and `dmaDone` outside the phase after the DMA acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| srcAddr | input | AW | Local source address |
| reqLen | input | LW | Requested byte count |
| notifyHost | input | 1 | Ask the host to interrupt itself on completion |
| timeoutCycles | input | TW | Cycle limit for the host buffer reply |
| bufReq | output | 1 | Host buffer request, held until acknowledged |
| bufReqAck | input | 1 | Host accepted the buffer request |
| bufRdy | input | 1 | Host buffer reply pulse |
| bufAddr | input | AW | Host buffer address, valid with `bufRdy` |
| bufSize | input | SW | Host buffer size exponent, valid with `bufRdy` |
| bufErr | input | 1 | Host buffer failure, valid with `bufRdy` |
| dmaReq | output | 1 | DMA request, held until acknowledged |
| dmaAck | input | 1 | DMA engine accepted the request |
| dmaSrc | output | AW | DMA source address |
| dmaDst | output | AW | DMA destination address |
| dmaLen | output | LW | DMA byte count |
| dmaSig | output | 1 | Host notification flag for this DMA |
| dmaDone | input | 1 | DMA completion pulse |
| dmaErr | input | 1 | DMA failure, valid with `dmaDone` |
| irq | output | 1 | Error interrupt, held until acknowledged |
| irqErr | output | 1 | Error qualifier of `irq` |
| irqAck | input | 1 | Interrupt acknowledge |
| busy | output | 1 | A transfer is in progress |
| xferDone | output | 1 | One-cycle pulse on successful completion |
| xferErr | output | 1 | One-cycle pulse when an error interrupt is acknowledged |

## Verification
Two events can land in the same cycle: the host's ready pulse and the expiry of the reply timer. The bench provokes this by timing the ready pulse for the last allowed cycle, and also one cycle later. It expects a DMA request in the first case and an error interrupt in the second. The bench also drives the buffer acknowledge and the ready pulse together, and checks that the wait phase is skipped cleanly. A behavioural model tracks the expected phase and the captured values, and the bench compares every output against it in every cycle.

// File: rtl/d2h_pkg.sv
package d2h_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BREQ  = 3'd1,
    ST_BWAIT = 3'd2,
    ST_DREQ  = 3'd3,
    ST_DWAIT = 3'd4,
    ST_IRQ   = 3'd5
  } seqState_t;

  typedef struct packed {
    logic loadReq;
    logic loadBuf;
  } seqStrb_t;

endpackage

// File: rtl/d2h_ctrl.sv
module d2h_ctrl
  import d2h_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [TW-1:0] timeoutCycles,
  input  logic          bufReqAck,
  input  logic          bufRdy,
  input  logic          bufErr,
  input  logic          dmaAck,
  input  logic          dmaDone,
  input  logic          dmaErr,
  input  logic          irqAck,
  output seqStrb_t      strb,
  output logic          bufReq,
  output logic          dmaReq,
  output logic          irq,
  output logic          irqErr,
  output logic          busy,
  output logic          xferDone,
  output logic          xferErr
);

  seqState_t     st, stNext;
  logic [TW-1:0] waitCnt;
  logic          inBuf;
  logic          expired;

  assign inBuf   = (st == ST_BREQ) || (st == ST_BWAIT);
  assign expired = inBuf && (({1'b0, waitCnt} + 1'b1) >= {1'b0, timeoutCycles});

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE:  if (start) stNext = ST_BREQ;
      ST_BREQ, ST_BWAIT: begin
        if (bufRdy)                          stNext = bufErr ? ST_IRQ : ST_DREQ;
        else if (expired)                    stNext = ST_IRQ;
        else if (st == ST_BREQ && bufReqAck) stNext = ST_BWAIT;
      end
      ST_DREQ:  if (dmaAck) stNext = ST_DWAIT;
      ST_DWAIT: if (dmaDone) stNext = dmaErr ? ST_IRQ : ST_IDLE;
      ST_IRQ:   if (irqAck) stNext = ST_IDLE;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      st <= stNext;
      if (strb.loadReq)  waitCnt <= '0;
      else if (inBuf)    waitCnt <= waitCnt + 1'b1;
    end
  end

  assign strb.loadReq = (st == ST_IDLE) && start;
  assign strb.loadBuf = inBuf && bufRdy && !bufErr;

  assign bufReq   = (st == ST_BREQ);
  assign dmaReq   = (st == ST_DREQ);
  assign irq      = (st == ST_IRQ);
  assign irqErr   = (st == ST_IRQ);
  assign busy     = (st != ST_IDLE);
  assign xferDone = (st == ST_DWAIT) && dmaDone && !dmaErr;
  assign xferErr  = (st == ST_IRQ) && irqAck;

endmodule

// File: rtl/d2h_dpath.sv
module d2h_dpath
  import d2h_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrb_t      strb,
  input  logic [AW-1:0] srcAddr,
  input  logic [LW-1:0] reqLen,
  input  logic          notifyHost,
  input  logic [AW-1:0] bufAddr,
  input  logic [SW-1:0] bufSize,
  output logic [AW-1:0] dmaSrc,
  output logic [AW-1:0] dmaDst,
  output logic [LW-1:0] dmaLen,
  output logic          dmaSig
);

  localparam logic [LW-1:0] ONE = {{(LW-1){1'b0}}, 1'b1};

  logic [AW-1:0] srcQ, dstQ;
  logic [LW-1:0] lenQ, dLenQ;
  logic          sigQ;
  logic [LW-1:0] bufBytes;
  logic [LW-1:0] clipLen;

  // buffer capacity in bytes; an exponent at or above LW cannot limit a LW-bit length
  always_comb begin
    bufBytes = ONE << bufSize;
    if (32'(bufSize) >= LW || lenQ <= bufBytes) clipLen = lenQ;
    else                                        clipLen = bufBytes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      lenQ  <= '0;
      sigQ  <= 1'b0;
      dstQ  <= '0;
      dLenQ <= '0;
    end else begin
      if (strb.loadReq) begin
        srcQ <= srcAddr;
        lenQ <= reqLen;
        sigQ <= notifyHost;
      end
      if (strb.loadBuf) begin
        dstQ  <= bufAddr;
        dLenQ <= clipLen;
      end
    end
  end

  assign dmaSrc = srcQ;
  assign dmaDst = dstQ;
  assign dmaLen = dLenQ;
  assign dmaSig = sigQ;

endmodule

// File: rtl/d2h_xfer_seq.sv
module d2h_xfer_seq
  import d2h_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32,
  parameter int SW = 6,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] srcAddr,
  input  logic [LW-1:0] reqLen,
  input  logic          notifyHost,
  input  logic [TW-1:0] timeoutCycles,
  output logic          bufReq,
  input  logic          bufReqAck,
  input  logic          bufRdy,
  input  logic [AW-1:0] bufAddr,
  input  logic [SW-1:0] bufSize,
  input  logic          bufErr,
  output logic          dmaReq,
  input  logic          dmaAck,
  output logic [AW-1:0] dmaSrc,
  output logic [AW-1:0] dmaDst,
  output logic [LW-1:0] dmaLen,
  output logic          dmaSig,
  input  logic          dmaDone,
  input  logic          dmaErr,
  output logic          irq,
  output logic          irqErr,
  input  logic          irqAck,
  output logic          busy,
  output logic          xferDone,
  output logic          xferErr
);

  seqStrb_t strb;

  d2h_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .timeoutCycles(timeoutCycles),
    .bufReqAck(bufReqAck), .bufRdy(bufRdy), .bufErr(bufErr),
    .dmaAck(dmaAck), .dmaDone(dmaDone), .dmaErr(dmaErr), .irqAck(irqAck),
    .strb(strb), .bufReq(bufReq), .dmaReq(dmaReq), .irq(irq), .irqErr(irqErr),
    .busy(busy), .xferDone(xferDone), .xferErr(xferErr)
  );

  d2h_dpath #(.AW(AW), .LW(LW), .SW(SW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .srcAddr(srcAddr), .reqLen(reqLen),
    .notifyHost(notifyHost), .bufAddr(bufAddr), .bufSize(bufSize),
    .dmaSrc(dmaSrc), .dmaDst(dmaDst), .dmaLen(dmaLen), .dmaSig(dmaSig)
  );

endmodule

// File: rtl/d2h_xfer_chk.sv
module d2h_xfer_chk #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          bufReq,
  input logic          bufReqAck,
  input logic          bufRdy,
  input logic          bufErr,
  input logic [AW-1:0] bufAddr,
  input logic          dmaReq,
  input logic          dmaAck,
  input logic [AW-1:0] dmaSrc,
  input logic [AW-1:0] dmaDst,
  input logic [LW-1:0] dmaLen,
  input logic          dmaSig,
  input logic          irq,
  input logic          irqErr,
  input logic          irqAck,
  input logic          busy,
  input logic          xferDone
);

  p_breq_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    bufReq && !bufReqAck && !bufRdy |=> bufReq || irq);

  p_dst_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(bufRdy) && !$past(bufErr) && (dmaDst == $past(bufAddr)));

  p_dreq_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && !dmaAck |=> dmaReq);

  p_dma_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq && $past(dmaReq) |-> $stable(dmaSrc) && $stable(dmaDst) && $stable(dmaLen) && $stable(dmaSig));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !busy);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq && !irqAck |=> irq && irqErr);

  p_one_phase_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bufReq, dmaReq, irq}));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !bufReq && !dmaReq && !irq);

endmodule

bind d2h_xfer_seq d2h_xfer_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rstN(rstN), .bufReq(bufReq), .bufReqAck(bufReqAck), .bufRdy(bufRdy),
  .bufErr(bufErr), .bufAddr(bufAddr), .dmaReq(dmaReq), .dmaAck(dmaAck),
  .dmaSrc(dmaSrc), .dmaDst(dmaDst), .dmaLen(dmaLen), .dmaSig(dmaSig),
  .irq(irq), .irqErr(irqErr), .irqAck(irqAck), .busy(busy), .xferDone(xferDone)
);

// File: tb/sim_d2h_xfer_seq.sv
module sim_d2h_xfer_seq;

  localparam int AW = 32, LW = 32, SW = 6, TW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic start = 0, notifyHost = 0, bufReqAck = 0, bufRdy = 0, bufErr = 0;
  logic dmaAck = 0, dmaDone = 0, dmaErr = 0, irqAck = 0;
  logic [AW-1:0] srcAddr = '0, bufAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic [SW-1:0] bufSize = '0;
  logic [TW-1:0] timeoutCycles = 16'd20;
  logic bufReq, dmaReq, dmaSig, irq, irqErr, busy, xferDone, xferErr;
  logic [AW-1:0] dmaSrc, dmaDst;
  logic [LW-1:0] dmaLen;

  d2h_xfer_seq #(.AW(AW), .LW(LW), .SW(SW), .TW(TW)) u0 (.*);

  int nChecks = 0, nFails = 0;
  string curTag = "R1";

  // behavioural reference: 0 idle,1 request,2 reply wait,3 dma request,4 dma wait,5 interrupt
  int mState = 0, mCnt = 0;
  longint mSrc = 0, mDst = 0, mLen = 0, mDlen = 0;
  bit mSig = 0;

  task automatic chk(string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", curTag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    longint cap;
    @(negedge clk);
    #1;
    if (rstN) begin
      chk("busy", busy, mState != 0);
      chk("bufReq", bufReq, mState == 1);
      chk("dmaReq", dmaReq, mState == 3);
      chk("irq", irq, mState == 5);
      chk("irqErr", irqErr, mState == 5);
      chk("xferDone", xferDone, mState == 4 && dmaDone && !dmaErr);
      chk("xferErr", xferErr, mState == 5 && irqAck);
      if (mState == 3) begin
        chk("dmaSrc", dmaSrc, mSrc);
        chk("dmaDst", dmaDst, mDst);
        chk("dmaLen", dmaLen, mDlen);
        chk("dmaSig", dmaSig, mSig);
      end
    end
    @(posedge clk);
    if (!rstN) mState = 0;
    else case (mState)
      0: if (start) begin
           mState = 1; mCnt = 0; mSrc = srcAddr; mLen = reqLen; mSig = notifyHost;
         end
      1, 2: if (bufRdy) begin
              if (bufErr) mState = 5;
              else begin
                mState = 3; mDst = bufAddr;
                cap = (bufSize >= LW) ? mLen : (longint'(1) << bufSize);
                mDlen = (mLen < cap) ? mLen : cap;
              end
            end else if (mCnt + 1 >= timeoutCycles) mState = 5;
            else begin
              if (mState == 1 && bufReqAck) mState = 2;
              mCnt++;
            end
      3: if (dmaAck) mState = 4;
      4: if (dmaDone) mState = dmaErr ? 5 : 0;
      5: if (irqAck) mState = 0;
      default: mState = 0;
    endcase
    #1;
    start = 0; bufReqAck = 0; bufRdy = 0; bufErr = 0;
    dmaAck = 0; dmaDone = 0; dmaErr = 0; irqAck = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic go(longint src, longint len, bit sig);
    srcAddr = AW'(src); reqLen = LW'(len); notifyHost = sig; start = 1; tick();
  endtask

  task automatic reply(longint addr, int size, bit err);
    bufAddr = AW'(addr); bufSize = SW'(size); bufErr = err; bufRdy = 1; tick();
  endtask

  task automatic finishDma(bit err);
    dmaAck = 1; tick(); idle(2);
    dmaDone = 1; dmaErr = err; tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(2);
    rstN = 1;
    curTag = "R1 reset state";
    idle(3);

    curTag = "R2 R4 R5 R6 R11 clipped transfer";
    go(64'h1000, 5000, 1);
    idle(2);
    start = 1; srcAddr = 32'hDEAD; tick();          // ignored while busy (R11)
    bufReqAck = 1; tick(); idle(2);
    reply(64'h8000_0000, 12, 0);                    // 4096 < 5000 (R4)
    dmaDone = 1; tick();                            // done before ack ignored (R11)
    idle(1);
    finishDma(0);
    idle(2);

    curTag = "R3 R4 ack and ready together";
    timeoutCycles = 16'd20;
    go(64'h2222, 300, 0);
    bufReqAck = 1; bufAddr = 32'h4000; bufSize = 10; bufRdy = 1; tick();
    finishDma(0);
    curTag = "R4 exponent beyond length width";
    go(64'h3333, 32'hFFFF_0000, 1);
    reply(64'h5000, 40, 0);
    finishDma(0);
    curTag = "R11 stray pulses while idle";
    bufRdy = 1; dmaDone = 1; irqAck = 1; tick(); idle(1);

    curTag = "R7 R10 timeout";
    timeoutCycles = 16'd8;
    go(64'h10, 64, 0);
    bufReqAck = 1; tick();
    idle(9);
    irqAck = 1; tick(); idle(1);

    curTag = "R7 ready in last allowed cycle";
    timeoutCycles = 16'd6;
    go(64'h20, 100, 0);
    idle(5);                                        // cycles 0..4
    reply(64'h6000, 6, 0);                          // cycle 5 accepted
    finishDma(0);

    curTag = "R7 ready one cycle late";
    go(64'h30, 100, 0);
    idle(6);
    reply(64'h7000, 6, 0);                          // arrives in interrupt phase
    idle(1);
    irqAck = 1; tick();

    curTag = "R7 zero limit";
    timeoutCycles = 16'd0;
    go(64'h31, 10, 0);
    idle(2);
    irqAck = 1; tick();

    curTag = "R8 buffer error";
    timeoutCycles = 16'd20;
    go(64'h40, 128, 1);
    idle(1);
    reply(64'h9000, 8, 1);
    idle(2);
    irqAck = 1; tick(); idle(1);

    curTag = "R9 R10 dma error";
    go(64'h50, 256, 1);
    reply(64'hA000, 4, 0);                          // clip to 16 bytes
    finishDma(1);
    idle(3);
    irqAck = 1; tick(); idle(2);

    summary();
  end

endmodule